// File: doc/BRIEF.md
# Dual-Channel PWM Timer with Waveform Modes

This block is a 16-bit timer/counter that drives two waveform output pins, A and B. A 4-bit waveform mode, supplied as two 2-bit fields, picks how the counter moves: a free run to all-ones, clear-on-compare, single-slope fast PWM, or dual-slope PWM in two flavours that differ only in when new compare values take effect. The mode also picks where the TOP value comes from: a fixed 8-, 9- or 10-bit limit, the capture register, or the active compare A value.

Each channel has a 2-bit output mode. It says whether the timer drives the pin and what the pin does on a compare match and at BOTTOM. The counter moves only on cycles where the `tick` enable from an outside prescaler is high. Software-side writes come in through a single write port with a 2-bit target select. The block reports the pin levels, their drive enables, one overflow pulse and one match pulse per channel. All outputs are registered, so each responds in the cycle after the tick that caused it.

Top module: `wavegen_timer`

## Requirements
- R1: After a synchronous reset the counter is 0 and counts upward. All compare, buffer and capture registers are 0. Both pins, both output enables and all pulses are low.
- R2: The counter changes only on cycles with `tick` high. A write with `wr_sel`=0 loads `wr_data` into the counter. On that cycle no match, overflow, pin or buffer-load event occurs, even if `tick` is high.
- R3: The mode number is {`wave_hi`,`wave_lo`}. Modes 0 and 13 count up to all-ones. Mode 4 is clear-on-compare with TOP = active compare A, and mode 12 is clear-on-compare with TOP = capture. Modes 5, 6 and 7 are fast PWM with TOP 0x00FF, 0x01FF and 0x03FF. Modes 14 and 15 are fast PWM with TOP = capture and TOP = compare A. In all of these, the tick taken at count == TOP moves the counter to 0.
- R4: Modes 1, 2 and 3 are dual-slope with TOP 0x00FF, 0x01FF and 0x03FF. Modes 10 and 11 are phase-correct with TOP = capture and TOP = compare A. Modes 8 and 9 are phase-and-frequency-correct with TOP = capture and TOP = compare A. While counting up, the tick at count >= TOP turns the counter down to count-1. While counting down, the tick at 0 turns it up to 1.
- R5: Output mode 00 drops the channel's output enable in the next cycle and leaves its pin level unchanged.
- R6: In modes 0, 4, 12 and 13, a tick at count == compare acts on either channel as follows: output mode 01 toggles the pin, 10 clears it, 11 sets it.
- R7: In fast PWM, output mode 10 clears the pin on a match tick and sets it on the tick that wraps the counter to 0. Output mode 11 does the opposite.
- R8: In fast PWM with output mode 10 or 11, if a channel's active compare equals TOP, its match action is dropped and only the wrap action is applied.
- R9: Output mode 01 in a PWM mode toggles channel A on a match only in modes 9, 11, 14 and 15. In every other PWM mode, and for channel B in all PWM modes, the channel is undriven (enable low, pin held).
- R10: In dual-slope modes, output mode 10 clears the pin on a match tick whose step goes up and sets it when the step goes down. Output mode 11 does the reverse. At a turning tick, the step direction is the new direction.
- R11: Writes with `wr_sel`=1 (compare A) and 2 (compare B) fill buffers. In modes 0, 4, 12 and 13 they also become active at once. Phase-correct modes copy the buffers to the active values on the tick that turns at TOP. Phase-and-frequency modes copy them on the tick that turns at BOTTOM. Fast PWM copies them on the wrap tick. A capture write (`wr_sel`=3) applies at once.
- R12: `match_a`/`match_b` are high for one cycle after each tick at which the count equals that channel's active compare, in every mode. `ovf_pulse` is high for one cycle after a wrap tick in modes 0, 13 and fast PWM, and after the BOTTOM-turn tick in dual-slope modes. It never fires in clear-on-compare modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable from the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 counter, 1 compare A, 2 compare B, 3 capture |
| wr_data | input | 16 | Write value |
| wave_lo | input | 2 | Waveform mode bits 1:0 |
| wave_hi | input | 2 | Waveform mode bits 3:2 |
| outmode_a | input | 2 | Output mode of channel A |
| outmode_b | input | 2 | Output mode of channel B |
| pin_a | output | 1 | Channel A pin level |
| pin_b | output | 1 | Channel B pin level |
| pin_a_oe | output | 1 | Channel A driven by the timer |
| pin_b_oe | output | 1 | Channel B driven by the timer |
| ovf_pulse | output | 1 | Overflow pulse |
| match_a | output | 1 | Channel A compare-match pulse |
| match_b | output | 1 | Channel B compare-match pulse |

## Verification
Clear-on-compare runs with toggle, clear and set on the two channels show whether the non-PWM output table is applied to both channels alike. Fast PWM runs use compare values inside the period, at 0 and equal to TOP, in both polarities. These separate the match action from the wrap action and expose the TOP rule. Dual-slope runs at compare 0 and at TOP check the choice of step direction on the turning ticks. Compare writes made mid-period, with sparse ticks, separate the three buffer-load points from each other and from immediate update. Output mode 01 is tried in every PWM family on both channels, so a wrong toggle permission shows up as a driven pin.

// File: rtl/wgt_pkg.sv
`timescale 1ns/1ps
package wgt_pkg;

    typedef enum logic [2:0] {
        K_NORMAL = 3'd0,
        K_CTC    = 3'd1,
        K_FAST   = 3'd2,
        K_PHASE  = 3'd3,
        K_PFREQ  = 3'd4
    } kind_e;

    typedef enum logic [2:0] {
        T_MAX  = 3'd0,
        T_8    = 3'd1,
        T_9    = 3'd2,
        T_10   = 3'd3,
        T_CAPT = 3'd4,
        T_CMPA = 3'd5
    } topsrc_e;

    typedef struct packed {
        kind_e   kind;
        topsrc_e tsrc;
        logic    tog_a;
    } mode_t;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2,
        ACT_TGL  = 2'd3
    } act_e;

    localparam logic [1:0] SEL_COUNT = 2'd0;
    localparam logic [1:0] SEL_CMPA  = 2'd1;
    localparam logic [1:0] SEL_CMPB  = 2'd2;
    localparam logic [1:0] SEL_CAPT  = 2'd3;

    function automatic mode_t decode_mode(input logic [3:0] m);
        mode_t r;
        r.kind  = K_NORMAL;
        r.tsrc  = T_MAX;
        r.tog_a = 1'b0;
        case (m)
            4'd1:  begin r.kind = K_PHASE; r.tsrc = T_8;    end
            4'd2:  begin r.kind = K_PHASE; r.tsrc = T_9;    end
            4'd3:  begin r.kind = K_PHASE; r.tsrc = T_10;   end
            4'd4:  begin r.kind = K_CTC;   r.tsrc = T_CMPA; end
            4'd5:  begin r.kind = K_FAST;  r.tsrc = T_8;    end
            4'd6:  begin r.kind = K_FAST;  r.tsrc = T_9;    end
            4'd7:  begin r.kind = K_FAST;  r.tsrc = T_10;   end
            4'd8:  begin r.kind = K_PFREQ; r.tsrc = T_CAPT; end
            4'd9:  begin r.kind = K_PFREQ; r.tsrc = T_CMPA; r.tog_a = 1'b1; end
            4'd10: begin r.kind = K_PHASE; r.tsrc = T_CAPT; end
            4'd11: begin r.kind = K_PHASE; r.tsrc = T_CMPA; r.tog_a = 1'b1; end
            4'd12: begin r.kind = K_CTC;   r.tsrc = T_CAPT; end
            4'd14: begin r.kind = K_FAST;  r.tsrc = T_CAPT; r.tog_a = 1'b1; end
            4'd15: begin r.kind = K_FAST;  r.tsrc = T_CMPA; r.tog_a = 1'b1; end
            default: ;
        endcase
        return r;
    endfunction

    function automatic logic is_dual(input kind_e k);
        return (k == K_PHASE) || (k == K_PFREQ);
    endfunction

    function automatic logic is_pwm(input kind_e k);
        return (k == K_FAST) || (k == K_PHASE) || (k == K_PFREQ);
    endfunction

    // Pin action for a compare hit; step_up is the direction of this tick's step.
    function automatic act_e hit_action(input kind_e k, input logic [1:0] om,
                                        input logic cmp_is_top, input logic step_up);
        act_e r;
        r = ACT_NONE;
        if (om == 2'b01) begin
            r = ACT_TGL;
        end else if (om[1]) begin
            case (k)
                K_NORMAL, K_CTC: r = om[0] ? ACT_SET : ACT_CLR;
                K_FAST:          r = cmp_is_top ? ACT_NONE : (om[0] ? ACT_SET : ACT_CLR);
                default:         r = (step_up ^ om[0]) ? ACT_CLR : ACT_SET;
            endcase
        end
        return r;
    endfunction

    // Pin action on the single-slope wrap to BOTTOM.
    function automatic act_e bottom_action(input kind_e k, input logic [1:0] om);
        act_e r;
        r = ACT_NONE;
        if (k == K_FAST && om[1]) r = om[0] ? ACT_CLR : ACT_SET;
        return r;
    endfunction

    function automatic logic apply_act(input logic cur, input act_e a);
        logic r;
        case (a)
            ACT_SET: r = 1'b1;
            ACT_CLR: r = 1'b0;
            ACT_TGL: r = ~cur;
            default: r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wgt_counter.sv
`timescale 1ns/1ps
module wgt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_ev,
    input  logic         cnt_wr,
    input  logic [W-1:0] wr_data,
    input  logic         dual,
    input  logic [W-1:0] top,
    output logic [W-1:0] cnt,
    output logic         step_up,
    output logic         wrap_ev,
    output logic         turn_top_ev,
    output logic         turn_bot_ev
);
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] ZERO = '0;

    logic         up_q;
    logic [W-1:0] nxt;
    logic         nxt_up;
    logic         wrap_c, ttop_c, tbot_c;

    always_comb begin
        nxt    = cnt;
        nxt_up = up_q;
        wrap_c = 1'b0;
        ttop_c = 1'b0;
        tbot_c = 1'b0;
        if (dual) begin
            if (up_q) begin
                if (cnt >= top) begin
                    ttop_c = 1'b1;
                    nxt_up = 1'b0;
                    nxt    = (cnt == ZERO) ? ZERO : cnt - ONE;
                end else begin
                    nxt = cnt + ONE;
                end
            end else begin
                if (cnt == ZERO) begin
                    tbot_c = 1'b1;
                    nxt_up = 1'b1;
                    nxt    = (top == ZERO) ? ZERO : ONE;
                end else begin
                    nxt = cnt - ONE;
                end
            end
        end else begin
            nxt_up = 1'b1;
            if (cnt == top) begin
                wrap_c = 1'b1;
                nxt    = ZERO;
            end else begin
                nxt = cnt + ONE;
            end
        end
    end

    assign step_up     = nxt_up;
    assign wrap_ev     = tick_ev & wrap_c;
    assign turn_top_ev = tick_ev & ttop_c;
    assign turn_bot_ev = tick_ev & tbot_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            up_q <= 1'b1;
        end else if (cnt_wr) begin
            cnt <= wr_data;
        end else if (tick_ev) begin
            cnt  <= nxt;
            up_q <= nxt_up;
        end
    end

    // R2: no tick and no write leaves the count alone
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!tick_ev && !cnt_wr) |=> (cnt == $past(cnt)));

    // R3: single-slope tick at TOP lands on BOTTOM
    a_r3_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        (tick_ev && !dual && cnt == top) |=> (cnt == '0));

    // R4: dual-slope bottom turn climbs to one
    a_r4_bottom_turn: assert property (@(posedge clk) disable iff (rst)
        (tick_ev && dual && !up_q && cnt == '0 && top != '0) |=> (cnt == ONE && up_q));

endmodule

// File: rtl/wgt_regs.sv
`timescale 1ns/1ps
module wgt_regs
    import wgt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [W-1:0]  wr_data,
    input  kind_e         kind,
    input  topsrc_e       tsrc,
    input  logic          load_ev,
    output logic [W-1:0]  act_a,
    output logic [W-1:0]  act_b,
    output logic [W-1:0]  top
);
    localparam logic [W-1:0] TOP_MAX = '1;
    localparam logic [W-1:0] TOP_8   = W'((1 << 8) - 1);
    localparam logic [W-1:0] TOP_9   = W'((1 << 9) - 1);
    localparam logic [W-1:0] TOP_10  = W'((1 << 10) - 1);

    logic [W-1:0] buf_a, buf_b, capt;
    logic         pwm;

    assign pwm = is_pwm(kind);

    always_comb begin
        case (tsrc)
            T_8:     top = TOP_8;
            T_9:     top = TOP_9;
            T_10:    top = TOP_10;
            T_CAPT:  top = capt;
            T_CMPA:  top = act_a;
            default: top = TOP_MAX;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_a <= '0;
            buf_b <= '0;
            act_a <= '0;
            act_b <= '0;
            capt  <= '0;
        end else begin
            if (wr_en && wr_sel == SEL_CMPA) buf_a <= wr_data;
            if (wr_en && wr_sel == SEL_CMPB) buf_b <= wr_data;
            if (wr_en && wr_sel == SEL_CAPT) capt  <= wr_data;
            if (!pwm) begin
                if (wr_en && wr_sel == SEL_CMPA) act_a <= wr_data;
                if (wr_en && wr_sel == SEL_CMPB) act_b <= wr_data;
            end else if (load_ev) begin
                act_a <= buf_a;
                act_b <= buf_b;
            end
        end
    end

    // R11: in PWM families the active value moves only at a load point
    a_r11_hold_between_loads: assert property (@(posedge clk) disable iff (rst)
        (pwm && !load_ev) |=> (act_a == $past(act_a) && act_b == $past(act_b)));

endmodule

// File: rtl/wgt_chan.sv
`timescale 1ns/1ps
module wgt_chan
    import wgt_pkg::*;
#(
    parameter int W    = 16,
    parameter bit IS_A = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  kind_e        kind,
    input  logic         tog_a,
    input  logic [1:0]   om,
    input  logic         tick_ev,
    input  logic         wrap_ev,
    input  logic         step_up,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    input  logic [W-1:0] top,
    output logic         pin,
    output logic         oe,
    output logic         match
);
    logic tog_ok, linked, hit, cmp_is_top;
    act_e a_hit, a_bot, a_fin;

    assign tog_ok     = (kind == K_NORMAL) || (kind == K_CTC) || (IS_A && tog_a);
    assign linked     = (om != 2'b00) && ((om != 2'b01) || tog_ok);
    assign hit        = tick_ev && (cnt == cmp);
    assign cmp_is_top = (cmp == top);

    always_comb begin
        a_hit = hit ? hit_action(kind, om, cmp_is_top, step_up) : ACT_NONE;
        a_bot = wrap_ev ? bottom_action(kind, om) : ACT_NONE;
        a_fin = (a_bot != ACT_NONE) ? a_bot : a_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin   <= 1'b0;
            oe    <= 1'b0;
            match <= 1'b0;
        end else begin
            oe    <= linked;
            match <= hit;
            if (linked) pin <= apply_act(pin, a_fin);
        end
    end

    // R5: disconnected channel keeps its level
    a_r5_hold_when_off: assert property (@(posedge clk) disable iff (rst)
        (om == 2'b00) |=> (pin == $past(pin) && !oe));

    // R8: compare at TOP in fast PWM yields the wrap action only
    a_r8_top_rule: assert property (@(posedge clk) disable iff (rst)
        (tick_ev && kind == K_FAST && cmp == top && cnt == top && om[1])
        |=> (pin == !$past(om[0])));

    generate
        if (!IS_A) begin : g_b_rule
            // R9: channel B never toggles in PWM families
            a_r9_b_no_toggle: assert property (@(posedge clk) disable iff (rst)
                (om == 2'b01 && kind != K_NORMAL && kind != K_CTC) |=> !oe);
        end
    endgenerate

endmodule

// File: rtl/wavegen_timer.sv
`timescale 1ns/1ps
module wavegen_timer
    import wgt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   wave_lo,
    input  logic [1:0]   wave_hi,
    input  logic [1:0]   outmode_a,
    input  logic [1:0]   outmode_b,
    output logic         pin_a,
    output logic         pin_b,
    output logic         pin_a_oe,
    output logic         pin_b_oe,
    output logic         ovf_pulse,
    output logic         match_a,
    output logic         match_b
);
    localparam int NCH = 2;

    mode_t        md;
    logic         cnt_wr, tick_ev, dual, load_ev;
    logic [W-1:0] cnt, top, act_a, act_b;
    logic         step_up, wrap_ev, turn_top_ev, turn_bot_ev;
    logic         ovf_q;

    logic [1:0]   om_arr  [NCH];
    logic [W-1:0] cmp_arr [NCH];
    logic         pin_arr [NCH];
    logic         oe_arr  [NCH];
    logic         mt_arr  [NCH];

    assign md      = decode_mode({wave_hi, wave_lo});
    assign cnt_wr  = wr_en && (wr_sel == SEL_COUNT);
    assign tick_ev = tick && !cnt_wr;
    assign dual    = is_dual(md.kind);

    always_comb begin
        case (md.kind)
            K_FAST:  load_ev = wrap_ev;
            K_PHASE: load_ev = turn_top_ev;
            K_PFREQ: load_ev = turn_bot_ev;
            default: load_ev = 1'b0;
        endcase
    end

    wgt_regs #(.W(W)) i_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .kind(md.kind), .tsrc(md.tsrc), .load_ev(load_ev),
        .act_a(act_a), .act_b(act_b), .top(top)
    );

    wgt_counter #(.W(W)) i_cnt (
        .clk(clk), .rst(rst), .tick_ev(tick_ev), .cnt_wr(cnt_wr), .wr_data(wr_data),
        .dual(dual), .top(top), .cnt(cnt), .step_up(step_up), .wrap_ev(wrap_ev),
        .turn_top_ev(turn_top_ev), .turn_bot_ev(turn_bot_ev)
    );

    assign om_arr[0]  = outmode_a;
    assign om_arr[1]  = outmode_b;
    assign cmp_arr[0] = act_a;
    assign cmp_arr[1] = act_b;

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            wgt_chan #(.W(W), .IS_A(g == 0)) i_ch (
                .clk(clk), .rst(rst), .kind(md.kind), .tog_a(md.tog_a), .om(om_arr[g]),
                .tick_ev(tick_ev), .wrap_ev(wrap_ev), .step_up(step_up),
                .cnt(cnt), .cmp(cmp_arr[g]), .top(top),
                .pin(pin_arr[g]), .oe(oe_arr[g]), .match(mt_arr[g])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) ovf_q <= 1'b0;
        else     ovf_q <= (wrap_ev && (md.kind == K_NORMAL || md.kind == K_FAST)) || turn_bot_ev;
    end

    assign pin_a     = pin_arr[0];
    assign pin_b     = pin_arr[1];
    assign pin_a_oe  = oe_arr[0];
    assign pin_b_oe  = oe_arr[1];
    assign match_a   = mt_arr[0];
    assign match_b   = mt_arr[1];
    assign ovf_pulse = ovf_q;

    // R12: an overflow pulse always follows an enabled tick
    a_r12_ovf_after_tick: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse |-> $past(tick));

endmodule

// File: tb/test_wavegen_timer.sv
`timescale 1ns/1ps
module test_wavegen_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [1:0]  wave_lo = 2'd0, wave_hi = 2'd0;
    logic [1:0]  outmode_a = 2'd0, outmode_b = 2'd0;
    logic        pin_a, pin_b, pin_a_oe, pin_b_oe, ovf_pulse, match_a, match_b;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    chk_on = 1'b0;
    bit    sparse = 1'b0;
    bit    done = 1'b0;
    int unsigned lf = 32'h1234_5678;
    string cur_req = "R1";

    always #2 clk = ~clk;

    wavegen_timer i_wavegen_timer (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .wave_lo(wave_lo), .wave_hi(wave_hi), .outmode_a(outmode_a), .outmode_b(outmode_b),
        .pin_a(pin_a), .pin_b(pin_b), .pin_a_oe(pin_a_oe), .pin_b_oe(pin_b_oe),
        .ovf_pulse(ovf_pulse), .match_a(match_a), .match_b(match_b)
    );

    // ---------------- reference model ----------------
    logic [15:0] m_cnt, m_capt, m_ba, m_bb, m_aa, m_ab;
    bit m_up, m_pa, m_pb, m_oa, m_ob, m_ov, m_ma, m_mb;

    // 0 free run, 1 clear-on-compare, 2 fast, 3 phase-correct, 4 phase-and-frequency
    function automatic int kind_of(int m);
        if (m == 4 || m == 12) return 1;
        if ((m >= 5 && m <= 7) || m == 14 || m == 15) return 2;
        if ((m >= 1 && m <= 3) || m == 10 || m == 11) return 3;
        if (m == 8 || m == 9) return 4;
        return 0;
    endfunction

    function automatic logic [15:0] top_of(int m, logic [15:0] a, logic [15:0] c);
        case (m)
            1, 5:            return 16'd255;
            2, 6:            return 16'd511;
            3, 7:            return 16'd1023;
            4, 9, 11, 15:    return a;
            8, 10, 12, 14:   return c;
            default:         return 16'hFFFF;
        endcase
    endfunction

    function automatic bit linked(int om, bit is_a, int k, int m);
        if (om == 0) return 1'b0;
        if (om != 1) return 1'b1;
        if (k <= 1) return 1'b1;
        if (!is_a) return 1'b0;
        if (k == 2) return (m == 14 || m == 15);
        return (m == 9 || m == 11);
    endfunction

    function automatic bit pin_upd(bit cur, int om, int k, bit hit, bit wrap, bit goes_up, bit at_top);
        bit r;
        r = cur;
        if (hit) begin
            if (om == 1)      r = !cur;
            else if (k <= 1)  r = (om == 3);
            else if (k == 2)  begin if (!at_top) r = (om == 3); end
            else              r = goes_up ? (om == 3) : (om == 2);
        end
        if (k == 2 && wrap && om >= 2) r = (om == 2);
        return r;
    endfunction

    always @(posedge clk) begin
        int m, k;
        logic [15:0] t, nc;
        bit la, lb, ld, hita, hitb, wrap, nup;
        if (rst) begin
            m_cnt = 0; m_capt = 0; m_ba = 0; m_bb = 0; m_aa = 0; m_ab = 0;
            m_up = 1; m_pa = 0; m_pb = 0; m_oa = 0; m_ob = 0; m_ov = 0; m_ma = 0; m_mb = 0;
        end else begin
            m  = int'({wave_hi, wave_lo});
            k  = kind_of(m);
            t  = top_of(m, m_aa, m_capt);
            la = linked(int'(outmode_a), 1'b1, k, m);
            lb = linked(int'(outmode_b), 1'b0, k, m);
            m_ov = 0; m_ma = 0; m_mb = 0; ld = 0;
            if (wr_en && wr_sel == 2'd0) begin
                m_cnt = wr_data;
            end else if (tick) begin
                hita = (m_cnt == m_aa);
                hitb = (m_cnt == m_ab);
                wrap = 0;
                if (k >= 3) begin
                    if (m_up) begin
                        if (m_cnt >= t) begin
                            nup = 0; nc = (m_cnt == 0) ? 16'd0 : m_cnt - 16'd1;
                            if (k == 3) ld = 1;
                        end else begin
                            nup = 1; nc = m_cnt + 16'd1;
                        end
                    end else if (m_cnt == 0) begin
                        nup = 1; nc = (t == 0) ? 16'd0 : 16'd1; m_ov = 1;
                        if (k == 4) ld = 1;
                    end else begin
                        nup = 0; nc = m_cnt - 16'd1;
                    end
                end else begin
                    nup = 1;
                    if (m_cnt == t) begin
                        wrap = 1; nc = 0;
                        if (k != 1) m_ov = 1;
                        if (k == 2) ld = 1;
                    end else begin
                        nc = m_cnt + 16'd1;
                    end
                end
                if (la) m_pa = pin_upd(m_pa, int'(outmode_a), k, hita, wrap, nup, m_aa == t);
                if (lb) m_pb = pin_upd(m_pb, int'(outmode_b), k, hitb, wrap, nup, m_ab == t);
                m_ma = hita; m_mb = hitb;
                m_cnt = nc; m_up = nup;
            end
            if (ld) begin m_aa = m_ba; m_ab = m_bb; end
            if (wr_en && wr_sel == 2'd1) begin m_ba = wr_data; if (k <= 1) m_aa = wr_data; end
            if (wr_en && wr_sel == 2'd2) begin m_bb = wr_data; if (k <= 1) m_ab = wr_data; end
            if (wr_en && wr_sel == 2'd3) m_capt = wr_data;
            m_oa = la; m_ob = lb;
        end
    end

    // ---------------- comparison, once per cycle ----------------
    always @(negedge clk) begin
        logic [6:0] got, exp;
        if (chk_on && !done) begin
            got = {pin_a, pin_b, pin_a_oe, pin_b_oe, ovf_pulse, match_a, match_b};
            exp = {m_pa, m_pb, m_oa, m_ob, m_ov, m_ma, m_mb};
            n_cmp++;
            if (got !== exp) begin
                n_bad++;
                $display("FAIL %s @%0t: {pa,pb,oea,oeb,ovf,ma,mb} actual %b expected %b",
                         cur_req, $time, got, exp);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic step(int n);
        repeat (n) begin
            @(negedge clk);
            lf = lf ^ (lf << 13);
            lf = lf ^ (lf >> 17);
            lf = lf ^ (lf << 5);
            tick = sparse ? lf[3] : 1'b1;
        end
    endtask

    task automatic put(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic setm(int m);
        {wave_hi, wave_lo} = 4'(m);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk_on = 1'b1;
        cur_req = "R1";           // reset state seen in the first comparisons
        step(4);

        cur_req = "R2";           // sparse ticks, counter load, wrap near all-ones
        sparse = 1; step(20);
        put(2'd0, 16'hFFF8); step(40);
        tick = 1; put(2'd0, 16'd3); step(5);

        cur_req = "R3";           // clear-on-compare with both TOP sources
        sparse = 0; setm(4); put(2'd1, 16'd9); step(30);
        setm(12); put(2'd3, 16'd12); step(40);

        cur_req = "R6";           // non-PWM toggle / clear / set on both channels
        setm(4); outmode_a = 2'd1; outmode_b = 2'd2; put(2'd2, 16'd4); step(30);
        outmode_b = 2'd3; step(25);
        outmode_b = 2'd1; step(25);

        cur_req = "R5";           // disconnect holds the level
        outmode_a = 2'd0; step(25);
        outmode_a = 2'd1; step(10);

        cur_req = "R7";           // fast PWM both polarities
        put(2'd0, 16'd0); setm(14); put(2'd3, 16'd9);
        put(2'd1, 16'd3); put(2'd2, 16'd6);
        outmode_a = 2'd2; outmode_b = 2'd3; step(40);

        cur_req = "R11";          // buffered updates mid-period, also with sparse ticks
        put(2'd1, 16'd7); step(3); put(2'd2, 16'd0); step(30);
        sparse = 1; put(2'd1, 16'd2); step(60); sparse = 0;

        cur_req = "R8";           // compare equal to TOP
        put(2'd1, 16'd9); put(2'd2, 16'd9); step(40);
        outmode_a = 2'd3; outmode_b = 2'd2; step(30);

        cur_req = "R9";           // toggle permission in PWM families
        setm(15); put(2'd1, 16'd5); outmode_a = 2'd1; outmode_b = 2'd1; step(40);
        setm(5); step(20);

        cur_req = "R4";           // phase-correct counting with capture TOP
        put(2'd0, 16'd0); setm(10); put(2'd3, 16'd6); put(2'd1, 16'd2); put(2'd2, 16'd4);
        outmode_a = 2'd2; outmode_b = 2'd3; step(40);

        cur_req = "R10";          // dual-slope at compare 0 and at TOP
        put(2'd1, 16'd0); put(2'd2, 16'd6); step(40);
        sparse = 1; step(60); sparse = 0;

        cur_req = "R11";          // phase-and-frequency load point
        setm(8); put(2'd1, 16'd3); put(2'd2, 16'd5); step(40);
        put(2'd1, 16'd1); step(30);

        cur_req = "R9";           // dual-slope toggle permission
        setm(9); put(2'd1, 16'd5); outmode_a = 2'd1; outmode_b = 2'd1; step(40);
        setm(11); step(30);
        setm(10); step(30);

        cur_req = "R12";          // fixed-TOP periods and pulses
        setm(1); outmode_a = 2'd2; outmode_b = 2'd3; put(2'd1, 16'd100); put(2'd2, 16'd200); step(600);
        setm(5); step(300);
        setm(13); put(2'd0, 16'hFFFA); step(20);

        step(2);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual run still going, expected completion");
            finish_run();
        end
    end

endmodule